// File: doc/BRIEF.md
# Word-Addressed Instruction Fetch Unit

This block holds the program counter of a 32-bit load/store processor that completes one instruction every cycle. It also works out the address of the next instruction on every clock. The counter stores only a word address. The unit appends two zero bits below that word address to form the byte address sent to the instruction memory. The memory returns the 32-bit word at that address, and the unit passes it back out, together with two fields taken from it: the immediate in the low bits and the jump field.

The next word address depends on three inputs. A branch request, an ALU zero flag and a jump request choose among three sources: the incremented counter, a branch target and a jump target. The branch target is the incremented counter plus the sign-extended immediate. The immediate counts in words, so it is added without a shift. The jump target keeps the top bits of the incremented counter and takes the jump field for the rest.

Top module: `fetch_unit`

## Requirements
- R1: While rst_ni is low, the program counter is zero and imem_addr_o reads zero, whatever branch_i, zero_i and jump_i do. The first fetch after reset is from address zero.
- R2: imem_addr_o[1:0] is always 2'b00. imem_addr_o[ADDR_W-1:2] is the word program counter.
- R3: When jump_i is 0 and branch_i and zero_i are not both 1, the word counter advances by one on each rising clock edge.
- R4: When jump_i is 0 and branch_i and zero_i are both 1, the next word counter is the current counter plus one plus imm_o sign-extended to the counter width, taken modulo the counter width. Negative offsets are included.
- R5: A branch request with zero_i at 0, or zero_i at 1 without a branch request, has no effect: the counter advances by one.
- R6: When jump_i is 1, the next word counter is the top ADDR_W-2-JFIELD_W bits of (counter plus one) followed by jfield_o. This holds whatever branch_i and zero_i are.
- R7: The top bits used for a jump come from the incremented counter. A jump issued from the last word of a region therefore lands in the following region.
- R8: instr_o equals imem_rdata_i. imm_o equals instr_o[IMM_W-1:0]. jfield_o equals instr_o[JFIELD_W-1:0].
- R9: Sequential flow from the all-ones word counter wraps to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the counter updates on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; clears the counter |
| branch_i | input | 1 | Branch request for the current instruction |
| zero_i | input | 1 | ALU zero flag |
| jump_i | input | 1 | Jump request; overrides any branch |
| imem_rdata_i | input | INSTR_W | Word returned by the instruction memory |
| imem_addr_o | output | ADDR_W | Byte address to the instruction memory, low two bits zero |
| instr_o | output | INSTR_W | Fetched instruction |
| imm_o | output | IMM_W | Immediate field, instr_o[IMM_W-1:0] |
| jfield_o | output | JFIELD_W | Jump field, instr_o[JFIELD_W-1:0] |

## Verification
The bench builds the unit with a 10-bit byte address, giving an 8-bit word counter. It uses a 5-bit jump field, which leaves 3 region bits, and a 4-bit immediate. At these sizes a long pseudo-random run reaches every counter value many times. It also covers the all-ones wrap and the last word of each 32-word region, where a jump crosses into the next region, and it exercises every immediate value from -8 to +7 as a taken branch. The memory word at each address is computed arithmetically from the address and a seed that changes during the run, so the immediate and jump fields vary at the same address.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  typedef enum logic [1:0] {
    SEL_SEQ    = 2'd0,
    SEL_BRANCH = 2'd1,
    SEL_JUMP   = 2'd2
  } nxt_sel_e;
endpackage

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg #(
  parameter int PC_W = 30
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] pc_d_i,
  output logic [PC_W-1:0] pc_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q_o <= '0;
    else         pc_q_o <= pc_d_i;
  end
endmodule

// File: rtl/fetch_incr.sv
module fetch_incr #(
  parameter int PC_W = 30
) (
  input  logic [PC_W-1:0] pc_i,
  output logic [PC_W-1:0] pc_inc_o
);
  // dedicated +1 adder, wraps modulo 2**PC_W
  assign pc_inc_o = pc_i + PC_W'(1);
endmodule

// File: rtl/fetch_target_gen.sv
module fetch_target_gen #(
  parameter int PC_W     = 30,
  parameter int IMM_W    = 16,
  parameter int JFIELD_W = 26
) (
  input  logic [PC_W-1:0]     pc_inc_i,
  input  logic [IMM_W-1:0]    imm_i,
  input  logic [JFIELD_W-1:0] jfield_i,
  output logic [PC_W-1:0]     br_tgt_o,
  output logic [PC_W-1:0]     jmp_tgt_o
);
  localparam int EXT_W = PC_W - IMM_W;
  localparam int REG_W = PC_W - JFIELD_W;

  logic [PC_W-1:0] offset;

  generate
    if (EXT_W > 0) begin : g_sext
      assign offset = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    end else begin : g_trunc
      assign offset = imm_i[PC_W-1:0];
    end
  endgenerate

  // word-granular offset: no shift
  assign br_tgt_o = pc_inc_i + offset;

  generate
    if (REG_W > 0) begin : g_region
      assign jmp_tgt_o = {pc_inc_i[PC_W-1 -: REG_W], jfield_i};
    end else begin : g_flat
      assign jmp_tgt_o = jfield_i[PC_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/fetch_field_split.sv
module fetch_field_split #(
  parameter int INSTR_W  = 32,
  parameter int IMM_W    = 16,
  parameter int JFIELD_W = 26
) (
  input  logic [INSTR_W-1:0]  instr_i,
  output logic [INSTR_W-1:0]  instr_o,
  output logic [IMM_W-1:0]    imm_o,
  output logic [JFIELD_W-1:0] jfield_o
);
  assign instr_o  = instr_i;
  assign imm_o    = instr_i[IMM_W-1:0];
  assign jfield_o = instr_i[JFIELD_W-1:0];
endmodule

// File: rtl/fetch_unit.sv
module fetch_unit
  import fetch_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int INSTR_W  = 32,
  parameter int IMM_W    = 16,
  parameter int JFIELD_W = 26
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                branch_i,
  input  logic                zero_i,
  input  logic                jump_i,
  input  logic [INSTR_W-1:0]  imem_rdata_i,
  output logic [ADDR_W-1:0]   imem_addr_o,
  output logic [INSTR_W-1:0]  instr_o,
  output logic [IMM_W-1:0]    imm_o,
  output logic [JFIELD_W-1:0] jfield_o
);
  localparam int PC_W = ADDR_W - 2;

  logic [PC_W-1:0] pc_q, pc_d, pc_inc, br_tgt, jmp_tgt;
  nxt_sel_e        sel;

  fetch_pc_reg #(.PC_W(PC_W)) u_pc_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pc_d_i (pc_d),
    .pc_q_o (pc_q)
  );

  fetch_incr #(.PC_W(PC_W)) u_incr (
    .pc_i     (pc_q),
    .pc_inc_o (pc_inc)
  );

  fetch_field_split #(
    .INSTR_W (INSTR_W),
    .IMM_W   (IMM_W),
    .JFIELD_W(JFIELD_W)
  ) u_split (
    .instr_i (imem_rdata_i),
    .instr_o (instr_o),
    .imm_o   (imm_o),
    .jfield_o(jfield_o)
  );

  fetch_target_gen #(
    .PC_W    (PC_W),
    .IMM_W   (IMM_W),
    .JFIELD_W(JFIELD_W)
  ) u_tgt (
    .pc_inc_i (pc_inc),
    .imm_i    (imm_o),
    .jfield_i (jfield_o),
    .br_tgt_o (br_tgt),
    .jmp_tgt_o(jmp_tgt)
  );

  // jump wins over branch
  always_comb begin
    if (jump_i)                 sel = SEL_JUMP;
    else if (branch_i && zero_i) sel = SEL_BRANCH;
    else                        sel = SEL_SEQ;
  end

  always_comb begin
    unique case (sel)
      SEL_JUMP:   pc_d = jmp_tgt;
      SEL_BRANCH: pc_d = br_tgt;
      default:    pc_d = pc_inc;
    endcase
  end

  assign imem_addr_o = {pc_q, 2'b00};
endmodule

// File: rtl/fetch_unit_chk.sv
module fetch_unit_chk #(
  parameter int ADDR_W   = 32,
  parameter int INSTR_W  = 32,
  parameter int IMM_W    = 16,
  parameter int JFIELD_W = 26
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                branch_i,
  input logic                zero_i,
  input logic                jump_i,
  input logic [INSTR_W-1:0]  imem_rdata_i,
  input logic [ADDR_W-1:0]   imem_addr_o,
  input logic [INSTR_W-1:0]  instr_o,
  input logic [IMM_W-1:0]    imm_o,
  input logic [JFIELD_W-1:0] jfield_o
);
  localparam int PC_W = ADDR_W - 2;
  localparam int REG_W = PC_W - JFIELD_W;
  localparam logic [PC_W-1:0] LOW_MASK = {PC_W{1'b1}} >> REG_W;

  logic [PC_W-1:0] pc, pc_nx, br_exp, jmp_exp;
  assign pc      = imem_addr_o[ADDR_W-1:2];
  assign pc_nx   = pc + PC_W'(1);
  assign br_exp  = pc_nx + PC_W'($signed(imm_o));
  assign jmp_exp = (pc_nx & ~LOW_MASK) | (PC_W'(jfield_o) & LOW_MASK);

  p_addr_aligned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_addr_o[1:0] == 2'b00);

  p_seq_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!jump_i && !branch_i && !zero_i) |=> pc == $past(pc_nx));

  p_branch_taken_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!jump_i && branch_i && zero_i) |=> pc == $past(br_exp));

  p_half_branch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!jump_i && (branch_i ^ zero_i)) |=> pc == $past(pc_nx));

  p_jump_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_i |=> pc == $past(jmp_exp));

  p_fields_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_o == imem_rdata_i && imm_o == imem_rdata_i[IMM_W-1:0]
      && jfield_o == imem_rdata_i[JFIELD_W-1:0]);
endmodule

bind fetch_unit fetch_unit_chk #(
  .ADDR_W  (ADDR_W),
  .INSTR_W (INSTR_W),
  .IMM_W   (IMM_W),
  .JFIELD_W(JFIELD_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .branch_i    (branch_i),
  .zero_i      (zero_i),
  .jump_i      (jump_i),
  .imem_rdata_i(imem_rdata_i),
  .imem_addr_o (imem_addr_o),
  .instr_o     (instr_o),
  .imm_o       (imm_o),
  .jfield_o    (jfield_o)
);

// File: tb/fetch_unit_tb.sv
module fetch_unit_tb;
  localparam int ADDR_W   = 10;
  localparam int INSTR_W  = 32;
  localparam int IMM_W    = 4;
  localparam int JFIELD_W = 5;
  localparam int PC_W     = ADDR_W - 2;
  localparam int PC_MOD   = 1 << PC_W;
  localparam int REGION   = 1 << JFIELD_W;
  localparam int N_STEPS  = 30000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                rst_ni, branch, zero, jump;
  logic [INSTR_W-1:0]  rdata, instr;
  logic [ADDR_W-1:0]   addr;
  logic [IMM_W-1:0]    imm;
  logic [JFIELD_W-1:0] jfield;
  int unsigned         seed_q;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  function automatic logic [31:0] mem_word(input logic [ADDR_W-1:0] a, input int unsigned s);
    logic [31:0] x;
    x = 32'(a >> 2) * 32'h9E3779B1 + s * 32'h7F4A7C15;
    x = x ^ (x >> 13);
    x = x * 32'h2C1B3C6D;
    return x ^ (x >> 17);
  endfunction

  assign rdata = mem_word(addr, seed_q);

  fetch_unit #(
    .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .IMM_W(IMM_W), .JFIELD_W(JFIELD_W)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .branch_i(branch), .zero_i(zero), .jump_i(jump),
    .imem_rdata_i(rdata), .imem_addr_o(addr), .instr_o(instr), .imm_o(imm),
    .jfield_o(jfield)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  int unsigned lfsr = 32'h1234_5678;
  function automatic int unsigned next_rand(input int unsigned v);
    return v * 32'd1103515245 + 32'd12345;
  endfunction

  initial begin
    int exp_pc;
    string tag;
    rst_ni = 1'b0; branch = 1'b0; zero = 1'b0; jump = 1'b0; seed_q = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1", 32'(addr), 32'd0);
    // controls toggled during reset must not move the counter
    jump = 1'b1; branch = 1'b1; zero = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1", 32'(addr), 32'd0);
    jump = 1'b0; branch = 1'b0; zero = 1'b0;
    rst_ni = 1'b1;
    exp_pc = 0;
    tag = "R1";
    for (int i = 0; i < N_STEPS; i++) begin
      int pc_inc, off;
      if (i % 700 == 699) seed_q = seed_q + 1;
      #1;
      chk("R2", 32'(addr[1:0]), 32'd0);
      chk(tag, 32'(addr >> 2), 32'(exp_pc));
      chk("R8", instr, mem_word(addr, seed_q));
      chk("R8", 32'(imm), mem_word(addr, seed_q) % (1 << IMM_W));
      chk("R8", 32'(jfield), mem_word(addr, seed_q) % (1 << JFIELD_W));
      lfsr = next_rand(lfsr);
      jump   = (lfsr[27:26] == 2'b00);
      branch = lfsr[24];
      zero   = lfsr[21];
      pc_inc = (exp_pc + 1) % PC_MOD;
      off = int'(imm);
      if (off >= (1 << (IMM_W - 1))) off = off - (1 << IMM_W);
      if (jump) begin
        tag = ((exp_pc % REGION) == REGION - 1) ? "R7" : "R6";
        exp_pc = (pc_inc / REGION) * REGION + int'(jfield);
      end else if (branch && zero) begin
        tag = "R4";
        exp_pc = (pc_inc + off + PC_MOD) % PC_MOD;
      end else if (branch || zero) begin
        tag = "R5";
        exp_pc = pc_inc;
      end else begin
        tag = (exp_pc == PC_MOD - 1) ? "R9" : "R3";
        exp_pc = pc_inc;
      end
      @(posedge clk); @(negedge clk);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule